// File: doc/BRIEF.md
# Gated Up/Down Edge Counter

This block counts rising edges of an asynchronous source signal, but only while a separate enable window input is high. Both inputs are brought into the system clock domain by two-flop synchronisers, and a rising edge is detected from the synchronised samples. The counter is 32 bits wide and starts from a parameterised initial value after reset. Software-independent logic can also load a new value at any time through a load strobe. Each qualified edge moves the count one step up or down.

A step that wraps the counter is the terminal event. Counting up from all-ones to zero is a wrap, and so is counting down from zero to all-ones. On that event the counter output either gives a fixed-width high pulse or inverts its level, depending on the mode input. The count direction can come from an external pin. It can also come from the block's own output level: a low output counts up and a high output counts down. When the output drives the direction, the counter starts one step below the wrap, and toggle mode is selected, every qualified edge wraps the counter again and flips the output. A single counter therefore marks each edge that falls inside the window.

Top module: `gated_edge_counter`

## Requirements
- R1: While reset is asserted and after it is released, the count equals the parameter INIT_COUNT (default 32'hFFFF_FFFF) and the counter output is low.
- R2: Each rising edge on src_in that is counted moves count_o by exactly one step. The new count appears at the third rising clock edge after the input change.
- R3: A rising edge on src_in while gate_in is low leaves count_o and ctr_out unchanged.
- R4: When dir_sel is 1, the direction follows ctr_out: low counts up and high counts down. When dir_sel is 0, the direction follows dir_down_in: 1 counts down and 0 counts up.
- R5: A step up from 32'hFFFF_FFFF gives zero, and a step down from zero gives 32'hFFFF_FFFF. Both of these steps are terminal events.
- R6: With mode_sel = 1 (toggle), ctr_out inverts on each terminal event, at the same clock edge as the count step.
- R7: With mode_sel = 0 (pulse), a terminal event drives ctr_out high for exactly PULSE_CYC clock cycles (default 3), after which it returns low.
- R8: load_en = 1 puts load_val into the count at the next clock edge and returns ctr_out low. A load takes priority over a step in the same cycle, and no terminal event occurs in that cycle.
- R9: With dir_sel = 1, toggle mode and a count of 32'hFFFF_FFFF from reset, each counted edge is a terminal event. The count alternates between zero and all-ones, and ctr_out changes level at every edge.
- R10: A step that is not a terminal event leaves ctr_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | 1 | Asynchronous edge source |
| gate_in | input | 1 | Asynchronous enable window; edges count only while high |
| load_en | input | 1 | Synchronous load strobe |
| load_val | input | WIDTH | Value loaded into the count |
| dir_sel | input | 1 | 1: direction from own output; 0: from dir_down_in |
| dir_down_in | input | 1 | External direction, 1 = down |
| mode_sel | input | 1 | 0: pulse on terminal event; 1: toggle on terminal event |
| count_o | output | WIDTH | Current count |
| ctr_out | output | 1 | Counter output |

## Verification
A change on src_in reaches count_o and ctr_out at the third rising clock edge after it. Two of those edges are synchroniser stages, and the third is the edge that registers the count and output together. A load appears one edge after the strobe. The bench drives its inputs on falling edges, waits the required number of rising edges, and samples on the next falling edge. Pulse width is checked by sampling ctr_out on each of the following falling edges until it is due to drop. The load-priority case raises the strobe in exactly the cycle in which the edge would be counted.

// File: rtl/gec_pkg.sv
package gec_pkg;
  typedef enum logic {
    OUT_PULSE  = 1'b0,
    OUT_TOGGLE = 1'b1
  } out_mode_e;
endpackage

// File: rtl/gec_rst_sync.sv
module gec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_n;

  always_comb stage_n = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_n;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/gec_sync.sv
module gec_sync #(
  parameter int unsigned BITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] d_in,
  output logic [BITS-1:0] q_out
);
  logic [BITS-1:0] meta_q;
  logic [BITS-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_in;
      sync_q <= meta_q;
    end
  end

  assign q_out = sync_q;
endmodule

// File: rtl/gec_count.sv
module gec_count #(
  parameter int unsigned    WIDTH      = 32,
  parameter logic [WIDTH-1:0] INIT_COUNT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_val,
  input  logic             step,
  input  logic             dir_down,
  output logic [WIDTH-1:0] count,
  output logic             term_hit
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_n;
  logic             at_edge;

  always_comb begin
    at_edge  = dir_down ? (cnt_q == '0) : (cnt_q == TOP);
    term_hit = step && !load_en && at_edge;
    cnt_n    = cnt_q;
    if (load_en)
      cnt_n = load_val;
    else if (step)
      cnt_n = dir_down ? cnt_q - 1'b1 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= INIT_COUNT;
    else        cnt_q <= cnt_n;
  end

  assign count = cnt_q;
endmodule

// File: rtl/gec_outstage.sv
module gec_outstage
  import gec_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  out_mode_e mode,
  input  logic      term_hit,
  input  logic      clear,
  output logic      out
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LEN_M1 = CW'(PULSE_CYC - 1);

  logic          out_q, out_n;
  logic [CW-1:0] left_q, left_n;

  always_comb begin
    out_n  = out_q;
    left_n = left_q;
    if (clear) begin
      out_n  = 1'b0;
      left_n = '0;
    end else if (term_hit) begin
      if (mode == OUT_TOGGLE) begin
        out_n  = ~out_q;
        left_n = '0;
      end else begin
        out_n  = 1'b1;
        left_n = LEN_M1;
      end
    end else if (mode == OUT_PULSE && out_q) begin
      if (left_q == '0) out_n  = 1'b0;
      else              left_n = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      left_q <= '0;
    end else begin
      out_q  <= out_n;
      left_q <= left_n;
    end
  end

  assign out = out_q;
endmodule

// File: rtl/gated_edge_counter.sv
module gated_edge_counter
  import gec_pkg::*;
#(
  parameter int unsigned      WIDTH      = 32,
  parameter logic [WIDTH-1:0] INIT_COUNT = '1,
  parameter int unsigned      PULSE_CYC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_in,
  input  logic             gate_in,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_val,
  input  logic             dir_sel,
  input  logic             dir_down_in,
  input  logic             mode_sel,
  output logic [WIDTH-1:0] count_o,
  output logic             ctr_out
);
  logic       srst_n;
  logic [1:0] sync_out;
  logic       src_s, gate_s;
  logic       src_d_q, src_d_n;
  logic       rise, step, dir_down, term_hit;

  gec_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  gec_sync #(.BITS(2)) u_sync (
    .clk(clk), .rst_n(srst_n),
    .d_in({gate_in, src_in}), .q_out(sync_out)
  );

  assign src_s  = sync_out[0];
  assign gate_s = sync_out[1];

  always_comb src_d_n = src_s;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) src_d_q <= 1'b0;
    else         src_d_q <= src_d_n;
  end

  always_comb begin
    rise     = src_s && !src_d_q;
    step     = rise && gate_s;
    dir_down = dir_sel ? ctr_out : dir_down_in;
  end

  gec_count #(.WIDTH(WIDTH), .INIT_COUNT(INIT_COUNT)) u_count (
    .clk(clk), .rst_n(srst_n), .load_en(load_en), .load_val(load_val),
    .step(step), .dir_down(dir_down), .count(count_o), .term_hit(term_hit)
  );

  gec_outstage #(.PULSE_CYC(PULSE_CYC)) u_out (
    .clk(clk), .rst_n(srst_n), .mode(out_mode_e'(mode_sel)),
    .term_hit(term_hit), .clear(load_en), .out(ctr_out)
  );
endmodule

// File: rtl/gec_checker.sv
module gec_checker #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             srst_n,
  input logic             load_en,
  input logic [WIDTH-1:0] load_val,
  input logic             mode_sel,
  input logic             term_hit,
  input logic [WIDTH-1:0] count,
  input logic             ctr_out
);
  localparam logic [WIDTH-1:0] TOP = '1;

  // R8
  load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    load_en |=> (count == $past(load_val)) && !ctr_out);

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !load_en |=> (count == $past(count)) || (count == $past(count) + 1'b1)
                 || (count == $past(count) - 1'b1));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!srst_n)
    term_hit |=> (count == '0) || (count == TOP));

  // R6
  toggle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (term_hit && mode_sel) |=> ctr_out != $past(ctr_out));

  // R7
  pulse_start_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (term_hit && !mode_sel) |=> ctr_out);

  // R10
  quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!term_hit && !load_en && mode_sel) |=> $stable(ctr_out));
endmodule

bind gated_edge_counter gec_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .srst_n(srst_n), .load_en(load_en), .load_val(load_val),
  .mode_sel(mode_sel), .term_hit(term_hit), .count(count_o), .ctr_out(ctr_out)
);

// File: tb/test_gated_edge_counter.sv
module test_gated_edge_counter;
  logic        clk = 1'b0;
  logic        rst_n, src_in, gate_in, load_en, dir_sel, dir_down_in, mode_sel;
  logic [31:0] load_val;
  logic [31:0] count_o;
  logic        ctr_out;
  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  gated_edge_counter i_gated_edge_counter (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .gate_in(gate_in),
    .load_en(load_en), .load_val(load_val), .dir_sel(dir_sel),
    .dir_down_in(dir_down_in), .mode_sel(mode_sel),
    .count_o(count_o), .ctr_out(ctr_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic m, logic ds);
    @(negedge clk);
    rst_n = 1'b0; src_in = 1'b0; gate_in = 1'b1; load_en = 1'b0;
    load_val = '0; dir_sel = ds; dir_down_in = 1'b0; mode_sel = m;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // raise src, wait three rising edges, return on the following falling edge
  task automatic edge_rise();
    src_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic edge_fall();
    src_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(1'b1, 1'b1);
    chk("R1 count", count_o, 32'hFFFF_FFFF);
    chk("R1 out", {31'b0, ctr_out}, 32'd0);
  endtask

  task automatic t_feedback();
    do_reset(1'b1, 1'b1);
    edge_rise();
    chk("R9/R5 count after edge1", count_o, 32'd0);
    chk("R6/R9 out after edge1", {31'b0, ctr_out}, 32'd1);
    edge_fall();
    edge_rise();
    chk("R9/R4 count after edge2", count_o, 32'hFFFF_FFFF);
    chk("R6/R9 out after edge2", {31'b0, ctr_out}, 32'd0);
    edge_fall();
    edge_rise();
    chk("R9 count after edge3", count_o, 32'd0);
    chk("R9 out after edge3", {31'b0, ctr_out}, 32'd1);
    edge_fall();
  endtask

  task automatic t_gate_low();
    gate_in = 1'b0;
    repeat (4) @(negedge clk);
    edge_rise();
    chk("R3 count", count_o, 32'd0);
    chk("R3 out", {31'b0, ctr_out}, 32'd1);
    edge_fall();
    gate_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 count after gate up", count_o, 32'd0);
  endtask

  task automatic t_timing();
    do_reset(1'b1, 1'b0);
    load_en = 1'b1; load_val = 32'd5;
    @(negedge clk);
    load_en = 1'b0;
    src_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 not yet stepped", count_o, 32'd5);
    @(posedge clk);
    @(negedge clk);
    chk("R2/R4 up step", count_o, 32'd6);
    chk("R10 out quiet", {31'b0, ctr_out}, 32'd0);
    edge_fall();
    dir_down_in = 1'b1;
    edge_rise();
    chk("R4 down step", count_o, 32'd5);
    edge_fall();
    load_en = 1'b1; load_val = 32'd0;
    @(negedge clk);
    load_en = 1'b0;
    edge_rise();
    chk("R5 down wrap", count_o, 32'hFFFF_FFFF);
    chk("R6 toggle on down wrap", {31'b0, ctr_out}, 32'd1);
    edge_fall();
  endtask

  task automatic t_pulse();
    do_reset(1'b0, 1'b0);
    edge_rise();
    chk("R5 up wrap", count_o, 32'd0);
    chk("R7 pulse cycle1", {31'b0, ctr_out}, 32'd1);
    @(negedge clk);
    chk("R7 pulse cycle2", {31'b0, ctr_out}, 32'd1);
    @(negedge clk);
    chk("R7 pulse cycle3", {31'b0, ctr_out}, 32'd1);
    @(negedge clk);
    chk("R7 pulse ended", {31'b0, ctr_out}, 32'd0);
    edge_fall();
    edge_rise();
    chk("R10 no pulse on non-terminal step", {31'b0, ctr_out}, 32'd0);
    chk("R2 step count", count_o, 32'd1);
    edge_fall();
  endtask

  task automatic t_load();
    do_reset(1'b1, 1'b1);
    edge_rise();
    edge_fall();
    chk("R8 precondition out", {31'b0, ctr_out}, 32'd1);
    load_en = 1'b1; load_val = 32'd42;
    @(negedge clk);
    load_en = 1'b0;
    chk("R8 load count", count_o, 32'd42);
    chk("R8 load clears out", {31'b0, ctr_out}, 32'd0);
    load_val = 32'hFFFF_FFFF;
    load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    src_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    load_en = 1'b1; load_val = 32'd77;
    @(posedge clk);
    @(negedge clk);
    load_en = 1'b0;
    chk("R8 load beats step", count_o, 32'd77);
    chk("R8 no terminal event", {31'b0, ctr_out}, 32'd0);
    edge_fall();
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_feedback();
    t_gate_low();
    t_timing();
    t_pulse();
    t_load();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule